// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block is a full-duplex serial port for 8-bit frames. A frame has no start, stop or parity bits. Each frame shifts one byte out on `sdo` and one byte in from `sdi`, both timed by a transfer clock. In internal mode the block makes the transfer clock itself from the system clock, with a selectable prescaler and an 8-bit divisor, and drives it onto `sclk_out`. In external mode it takes the clock from `sclk_in` through a synchronizer and leaves the pin undriven.

The CPU side is a set of plain strobes and level controls. A write loads the transmit holding byte, and a read strobe frees the receive holding byte. The level controls select the enables, the transmit interrupt source, clock polarity, bit order and continuous receive. A frame starts only when transmit is enabled and a byte is waiting, so a receive-only transfer still needs a dummy byte, unless continuous receive re-arms the port. The block raises single-cycle transmit and receive interrupt pulses and a sticky overrun flag.

The sequencer has three states. `ST_IDLE` moves to `ST_SHIFT` when a frame may start (transition *launch*). `ST_SHIFT` moves to `ST_DONE` on the eighth trailing clock edge (transition *last_bit*). `ST_DONE` hands the received byte over and returns to `ST_IDLE` one cycle later (transition *handoff*). No other transitions exist.

Top module: `csio_port`

## Requirements
- R1: A frame carries exactly 8 data bits, then `ST_DONE` lasts one cycle. With `sdo` looped back to `sdi`, the byte that arrives in `rx_rdata` equals the byte written.
- R2: With `ext_clk`=0, `sclk_oe` is 1 and each half period of `sclk_out` lasts (`baud_div`+1)·P system cycles. P is selected by `presc_sel`: 00 gives P=1, 01 gives P=8, 10 and 11 give P=32. With `ext_clk`=1, `sclk_oe` is 0.
- R3: Outside a frame, `sclk_out` rests at its idle level: high when `clk_pol`=0, low when `clk_pol`=1.
- R4: A frame starts only when `tx_en`=1 and `tx_empty`=0. A `tx_wr` clears `tx_empty`. Moving the byte into the shifter sets `tx_empty`.
- R5: A frame with `rx_en`=0 neither changes `rx_rdata` nor pulses `rx_irq`. Setting `rx_en`=1 with no byte waiting starts nothing.
- R6: With `txirq_sel`=0, `tx_irq` pulses in the cycle after the byte moves into the shifter. With `txirq_sel`=1, it pulses when the frame completes, in the same cycle as `rx_irq`.
- R7: `rx_irq` pulses for one cycle when a completed frame is written into `rx_rdata`. A `rx_rd` strobe marks that byte as consumed.
- R8: The overrun flag is set when the 7th bit of a frame is sampled while the previous byte is still unconsumed. That frame is then discarded: `rx_rdata` keeps its old byte and `rx_irq` stays low. The flag stays set until `rx_en` is 0.
- R9: Using clk_pol=0 or clk_pol=1, `sdo` changes on the edge that leaves the idle level (the leading edge), and `sdi` is sampled on the edge that returns to it (the trailing edge).
- R10: `msb_first`=1 sends and receives bit 7 first. `msb_first`=0 sends and receives bit 0 first.
- R11: With `ext_clk`=1, leading and trailing edges are taken from `sclk_in` after a two-stage synchronizer.
- R12: With `cont_rx`=1 and `rx_en`=1, an `rx_rd` strobe starts one more frame without a new write. That frame resends the held transmit byte, leaves `tx_empty` at 1 and does not pulse a `txirq_sel`=0 interrupt. Without a further read, no further frame starts.
- R13: After reset, `tx_empty`=1, `sdo`=1, `rx_rdata`=0, and `tx_irq`, `rx_irq` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_wr | input | 1 | Write strobe for the transmit holding byte |
| tx_wdata | input | DATA_W | Byte to transmit |
| rx_rd | input | 1 | Read strobe, consumes the received byte |
| rx_rdata | output | DATA_W | Receive holding byte |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| txirq_sel | input | 1 | Transmit interrupt source: 0 buffer moved, 1 frame done |
| clk_pol | input | 1 | Clock polarity: 0 idles high, 1 idles low |
| msb_first | input | 1 | Bit order select |
| cont_rx | input | 1 | Continuous receive select |
| ext_clk | input | 1 | 1 selects the clock from `sclk_in` |
| presc_sel | input | 2 | Prescaler select |
| baud_div | input | DIV_W | Half-period divisor n |
| tx_empty | output | 1 | Transmit holding byte is free |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |
| overrun | output | 1 | Sticky overrun flag |
| sclk_in | input | 1 | External transfer clock |
| sclk_out | output | 1 | Generated transfer clock |
| sclk_oe | output | 1 | Drive enable for `sclk_out` |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The hardest state to reach is an overrun. It needs a full receive byte left unread across a whole second frame. The check then has to confirm that the discarded frame leaves no trace in `rx_rdata` or `rx_irq`. The bench reaches it on purpose: it runs two back-to-back transfers with no read strobe between them, then reads and drops `rx_en` to show that the flag clears only through the enable. Continuous receive is the second hard case. A frame has to start with no write at all, so the bench loops `sdo` back to `sdi`, which makes the resent byte visible in `rx_rdata`.

// File: rtl/csio_pkg.sv
`timescale 1ns/1ps
package csio_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } csio_state_e;

    localparam int PRE_MID = 8;
    localparam int PRE_MAX = 32;
endpackage

// File: rtl/csio_baud.sv
`timescale 1ns/1ps
module csio_baud #(
    parameter int DIV_W   = 8,
    parameter int PRE_MID = 8,
    parameter int PRE_MAX = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       psel,
    input  logic [DIV_W-1:0] div,
    output logic             lead,
    output logic             trail,
    output logic             lvl
);
    localparam int PRE_W = (PRE_MAX > 1) ? $clog2(PRE_MAX) : 1;

    logic [PRE_W-1:0] pcnt;
    logic [PRE_W-1:0] plim;
    logic [DIV_W-1:0] dcnt;
    logic             tick;
    logic             flip;

    always_comb begin
        unique case (psel)
            2'b00:   plim = '0;
            2'b01:   plim = PRE_W'(PRE_MID - 1);
            default: plim = PRE_W'(PRE_MAX - 1);
        endcase
    end

    assign tick  = run && (pcnt == plim);
    assign flip  = tick && (dcnt == div);
    assign lead  = flip && !lvl;
    assign trail = flip && lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
            dcnt <= '0;
            lvl  <= 1'b0;
        end else if (!run) begin
            pcnt <= '0;
            dcnt <= '0;
            lvl  <= 1'b0;
        end else if (tick) begin
            pcnt <= '0;
            if (flip) begin
                dcnt <= '0;
                lvl  <= ~lvl;
            end else begin
                dcnt <= dcnt + 1'b1;
            end
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/csio_extsync.sv
`timescale 1ns/1ps
module csio_extsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pol,
    output logic lead,
    output logic trail
);
    logic [STAGES-1:0] chain;
    logic              norm;
    logic              prev;

    assign norm  = pol ? chain[STAGES-1] : ~chain[STAGES-1];
    assign lead  = norm & ~prev;
    assign trail = ~norm & prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], pin};
            prev  <= norm;
        end
    end
endmodule

// File: rtl/csio_shifter.sv
`timescale 1ns/1ps
module csio_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              msb_first,
    input  logic              lead,
    input  logic              trail,
    input  logic              din,
    output logic              dout,
    output logic [DATA_W-1:0] rx_word
);
    logic [DATA_W-1:0] tx_sh;
    logic              out_bit;

    assign out_bit = msb_first ? tx_sh[DATA_W-1] : tx_sh[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh   <= '0;
            rx_word <= '0;
            dout    <= 1'b1;
        end else begin
            if (load) begin
                tx_sh <= load_data;
            end else if (lead) begin
                dout  <= out_bit;
                tx_sh <= msb_first ? {tx_sh[DATA_W-2:0], 1'b0}
                                   : {1'b0, tx_sh[DATA_W-1:1]};
            end
            if (trail) begin
                rx_word <= msb_first ? {rx_word[DATA_W-2:0], din}
                                     : {din, rx_word[DATA_W-1:1]};
            end
            if (idle) begin
                dout <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/csio_port.sv
`timescale 1ns/1ps
module csio_port #(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int OVR_BIT     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_rdata,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              txirq_sel,
    input  logic              clk_pol,
    input  logic              msb_first,
    input  logic              cont_rx,
    input  logic              ext_clk,
    input  logic [1:0]        presc_sel,
    input  logic [DIV_W-1:0]  baud_div,
    output logic              tx_empty,
    output logic              tx_irq,
    output logic              rx_irq,
    output logic              overrun,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sclk_oe,
    output logic              sdo,
    input  logic              sdi
);
    import csio_pkg::*;

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    csio_state_e       st, st_nx;
    logic [DATA_W-1:0] tx_buf;
    logic [DATA_W-1:0] rx_word;
    logic              rx_full;
    logic              rearm;
    logic              rx_armed;
    logic              frame_ovr;
    logic [CNT_W-1:0]  bitcnt;

    logic start_buf, start_rearm, go;
    logic int_lead, int_trail, int_lvl;
    logic ext_lead, ext_trail;
    logic sh_lead, sh_trail;
    logic last_bit;

    // launch conditions
    assign start_buf   = tx_en && !tx_empty;
    assign start_rearm = tx_en && rx_en && cont_rx && rearm && tx_empty;
    assign go          = (st == ST_IDLE) && (st_nx == ST_SHIFT);

    // edge selection between generated and pin clock
    assign sh_lead  = (st == ST_SHIFT) && (ext_clk ? ext_lead  : int_lead);
    assign sh_trail = (st == ST_SHIFT) && (ext_clk ? ext_trail : int_trail);
    assign last_bit = sh_trail && (bitcnt == CNT_W'(DATA_W - 1));

    assign sclk_out = clk_pol ? int_lvl : ~int_lvl;
    assign sclk_oe  = ~ext_clk;

    csio_baud #(
        .DIV_W  (DIV_W),
        .PRE_MID(PRE_MID),
        .PRE_MAX(PRE_MAX)
    ) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .run  ((st == ST_SHIFT) && !ext_clk),
        .psel (presc_sel),
        .div  (baud_div),
        .lead (int_lead),
        .trail(int_trail),
        .lvl  (int_lvl)
    );

    csio_extsync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (sclk_in),
        .pol  (clk_pol),
        .lead (ext_lead),
        .trail(ext_trail)
    );

    csio_shifter #(
        .DATA_W(DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .idle     (st == ST_IDLE),
        .load     (go),
        .load_data(tx_buf),
        .msb_first(msb_first),
        .lead     (sh_lead),
        .trail    (sh_trail),
        .din      (sdi),
        .dout     (sdo),
        .rx_word  (rx_word)
    );

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (start_buf || start_rearm) st_nx = ST_SHIFT;
            ST_SHIFT: if (last_bit)                 st_nx = ST_DONE;
            ST_DONE:                                st_nx = ST_IDLE;
            default:                                st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // buffers, flags and interrupt pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_buf    <= '0;
            tx_empty  <= 1'b1;
            rx_rdata  <= '0;
            rx_full   <= 1'b0;
            rearm     <= 1'b0;
            rx_armed  <= 1'b0;
            frame_ovr <= 1'b0;
            bitcnt    <= '0;
            tx_irq    <= 1'b0;
            rx_irq    <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            tx_irq <= 1'b0;
            rx_irq <= 1'b0;

            if (go) begin
                rx_armed  <= rx_en;
                frame_ovr <= 1'b0;
                bitcnt    <= '0;
                if (start_buf) begin
                    tx_empty <= 1'b1;
                    if (!txirq_sel) tx_irq <= 1'b1;
                end
            end

            if (tx_wr) begin
                tx_buf   <= tx_wdata;
                tx_empty <= 1'b0;
            end

            if (!cont_rx)   rearm <= 1'b0;
            else if (rx_rd) rearm <= 1'b1;
            else if (go)    rearm <= 1'b0;

            if (rx_rd) rx_full <= 1'b0;

            if (sh_trail) begin
                bitcnt <= bitcnt + 1'b1;
                if (rx_armed && rx_full && (bitcnt == CNT_W'(OVR_BIT))) begin
                    frame_ovr <= 1'b1;
                    overrun   <= 1'b1;
                end
            end

            if (st == ST_DONE) begin
                if (rx_armed && !frame_ovr) begin
                    rx_rdata <= rx_word;
                    rx_full  <= 1'b1;
                    rx_irq   <= 1'b1;
                end
                if (txirq_sel) tx_irq <= 1'b1;
            end

            if (!rx_en) overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/csio_port_chk.sv
`timescale 1ns/1ps
module csio_port_chk (
    input logic                  clk,
    input logic                  rst_n,
    input csio_pkg::csio_state_e st,
    input logic                  tx_en,
    input logic                  tx_empty,
    input logic                  tx_wr,
    input logic                  ext_clk,
    input logic                  clk_pol,
    input logic                  sclk_out,
    input logic                  rx_irq,
    input logic                  rx_full,
    input logic                  rx_en,
    input logic                  overrun,
    input logic                  tx_irq,
    input logic                  txirq_sel
);
    import csio_pkg::*;

    // R3: generated clock rests at idle level between frames
    assert_idle_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_clk && st == ST_IDLE) |-> (sclk_out == !clk_pol));

    // R4: no launch while transmit is disabled
    assert_start_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !tx_en) |=> (st != ST_SHIFT));

    // R4: a waiting byte with transmit enabled is taken at once
    assert_buf_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && tx_en && !tx_empty) |=>
            (st == ST_SHIFT && (tx_empty || $past(tx_wr))));

    // R1: the handoff state lasts exactly one cycle
    assert_done_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE) |=> (st == ST_IDLE));

    // R7: a receive pulse always comes with a full holding byte
    assert_rx_irq_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_full);

    // R8: overrun only rises on an unconsumed byte with receive enabled
    assert_ovr_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> ($past(rx_full) && $past(rx_en)));

    // R6: buffer-moved pulse appears as shifting begins
    assert_txirq_early_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && !$past(txirq_sel)) |-> (st == ST_SHIFT));

    // R6: frame-done pulse appears after the handoff
    assert_txirq_late_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && $past(txirq_sel)) |-> (st == ST_IDLE));
endmodule

bind csio_port csio_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st),
    .tx_en    (tx_en),
    .tx_empty (tx_empty),
    .tx_wr    (tx_wr),
    .ext_clk  (ext_clk),
    .clk_pol  (clk_pol),
    .sclk_out (sclk_out),
    .rx_irq   (rx_irq),
    .rx_full  (rx_full),
    .rx_en    (rx_en),
    .overrun  (overrun),
    .tx_irq   (tx_irq),
    .txirq_sel(txirq_sel)
);

// File: tb/sim_csio_port.sv
`timescale 1ns/1ps
module sim_csio_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_wr = 1'b0, rx_rd = 1'b0;
    logic [7:0] tx_wdata = '0;
    logic [7:0] rx_rdata;
    logic       tx_en = 1'b0, rx_en = 1'b0, txirq_sel = 1'b0, clk_pol = 1'b0;
    logic       msb_first = 1'b0, cont_rx = 1'b0, ext_clk = 1'b0;
    logic [1:0] presc_sel = 2'b00;
    logic [7:0] baud_div = 8'd0;
    logic       tx_empty, tx_irq, rx_irq, overrun;
    logic       sclk_in = 1'b1, sclk_out, sclk_oe, sdo;
    logic       sdi_drv = 1'b1, loop = 1'b1;
    logic       sdi;

    assign sdi = loop ? sdo : sdi_drv;

    always #5 clk = ~clk;

    csio_port u0 (
        .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
        .rx_rd(rx_rd), .rx_rdata(rx_rdata), .tx_en(tx_en), .rx_en(rx_en),
        .txirq_sel(txirq_sel), .clk_pol(clk_pol), .msb_first(msb_first),
        .cont_rx(cont_rx), .ext_clk(ext_clk), .presc_sel(presc_sel),
        .baud_div(baud_div), .tx_empty(tx_empty), .tx_irq(tx_irq),
        .rx_irq(rx_irq), .overrun(overrun), .sclk_in(sclk_in),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdo(sdo), .sdi(sdi)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: interrupt timestamps, clock toggles, transmitted bits
    int       rxi_n = 0, txi_n = 0, rxi_cyc = 0, txi_cyc = 0;
    int       tog_n = 0, last_tog = 0, hp_min = 0, hp_max = 0, ncap = 0;
    bit       have_tog = 0;
    logic     prev_sclk = 1'b1;
    logic [7:0] cap = '0;

    always @(negedge clk) begin
        if (rx_irq) begin rxi_n++; rxi_cyc = cyc; end
        if (tx_irq) begin txi_n++; txi_cyc = cyc; end
        if (rst_n && sclk_out !== prev_sclk) begin
            tog_n++;
            if (have_tog) begin
                if (cyc - last_tog < hp_min) hp_min = cyc - last_tog;
                if (cyc - last_tog > hp_max) hp_max = cyc - last_tog;
            end
            have_tog = 1;
            last_tog = cyc;
            if (sclk_out == !clk_pol) begin
                if (ncap < 8) cap[ncap] = sdo;
                ncap++;
            end
        end
        prev_sclk = sclk_out;
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic clear_mon();
        ncap = 0; tog_n = 0; have_tog = 0; hp_min = 1000000; hp_max = 0;
    endtask

    task automatic wr(input logic [7:0] d);
        tx_wdata = d; tx_wr = 1'b1;
        step();
        tx_wr = 1'b0;
    endtask

    task automatic rd();
        rx_rd = 1'b1;
        step();
        rx_rd = 1'b0;
    endtask

    task automatic wait_cnt(ref int cnt, input int base, input int lim);
        for (int k = 0; k < lim && cnt == base; k++) step();
        repeat (3) step();
    endtask

    function automatic logic bit_at(logic [7:0] d, int i, logic msb);
        return msb ? d[7-i] : d[i];
    endfunction

    function automatic logic [7:0] wire_order(logic [7:0] d, logic msb);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = bit_at(d, i, msb);
        return r;
    endfunction

    function automatic int half_period(logic [1:0] ps, logic [7:0] n);
        int p;
        p = (ps == 2'b00) ? 1 : (ps == 2'b01) ? 8 : 32;
        return (int'(n) + 1) * p;
    endfunction

    // internal-clock loopback frame with full checking
    task automatic int_frame(input logic [7:0] d, input logic pol, input logic msb,
                             input logic [1:0] ps, input logic [7:0] n, input logic isel);
        int n0, t0, hp;
        clk_pol = pol; msb_first = msb; presc_sel = ps; baud_div = n;
        txirq_sel = isel; ext_clk = 1'b0; loop = 1'b1; tx_en = 1'b1; rx_en = 1'b1;
        repeat (3) step();
        clear_mon();
        n0 = rxi_n; t0 = txi_n;
        hp = half_period(ps, n);
        wr(d);
        wait_cnt(rxi_n, n0, 40000);
        chk(rxi_n == n0 + 1, "R7", "rx_irq pulses", rxi_n - n0, 1);
        chk(rx_rdata == d, "R1", "loopback byte", rx_rdata, d);
        chk(ncap == 8, "R1", "trailing edges per frame", ncap, 8);
        chk(cap == wire_order(d, msb), "R10", "bit order on sdo", cap, wire_order(d, msb));
        chk(hp_min == hp && hp_max == hp, "R2", "half period", hp_max, hp);
        chk(sclk_out == !pol, "R3", "clock idle after frame", sclk_out, !pol);
        chk(tx_empty == 1'b1, "R4", "buffer freed", tx_empty, 1);
        chk(txi_n == t0 + 1, "R6", "tx_irq count", txi_n - t0, 1);
        if (isel)
            chk(txi_cyc == rxi_cyc, "R6", "frame-done tx_irq cycle", txi_cyc, rxi_cyc);
        else
            chk(rxi_cyc - txi_cyc >= 15 * hp, "R6", "buffer-moved tx_irq lead",
                rxi_cyc - txi_cyc, 15 * hp);
        rd();
    endtask

    // external-clock frame: bench is the clock master
    task automatic ext_frame(input logic [7:0] dt, input logic [7:0] dr,
                             input logic pol, input logic msb);
        int n0;
        logic [7:0] got;
        localparam int H = 8;
        clk_pol = pol; msb_first = msb; ext_clk = 1'b1; loop = 1'b0;
        tx_en = 1'b1; rx_en = 1'b1; txirq_sel = 1'b1;
        sclk_in = pol ? 1'b0 : 1'b1;
        repeat (4) step();
        chk(sclk_oe == 1'b0, "R2", "sclk_oe in external mode", sclk_oe, 0);
        clear_mon();
        n0 = rxi_n;
        wr(dt);
        repeat (4) step();
        for (int i = 0; i < 8; i++) begin
            sclk_in = ~sclk_in;
            sdi_drv = bit_at(dr, i, msb);
            repeat (H) step();
            got[i] = sdo;
            sclk_in = ~sclk_in;
            repeat (H) step();
        end
        wait_cnt(rxi_n, n0, 50);
        chk(rx_rdata == dr, "R11", "byte from pin clock", rx_rdata, dr);
        chk(got == wire_order(dt, msb), "R9", "sdo at leading edges", got, wire_order(dt, msb));
        chk(tog_n == 0, "R3", "no generated clock in external mode", tog_n, 0);
        rd();
        ext_clk = 1'b0; loop = 1'b1;
        repeat (3) step();
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog run did not end actual=%0d expected=%0d", cyc, 190000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] keep;
        int n0, t0;
        void'($urandom(32'd4242));
        repeat (5) step();
        rst_n = 1'b1;
        step();

        // R13 reset state
        chk(tx_empty == 1'b1, "R13", "tx_empty", tx_empty, 1);
        chk(sdo == 1'b1, "R13", "sdo", sdo, 1);
        chk(rx_rdata == 8'h00, "R13", "rx_rdata", rx_rdata, 0);
        chk({tx_irq, rx_irq, overrun} == 3'b000, "R13", "irq and overrun", {tx_irq, rx_irq, overrun}, 0);
        chk(sclk_out == 1'b1, "R3", "idle high with pol 0", sclk_out, 1);
        chk(sclk_oe == 1'b1, "R2", "sclk_oe internal", sclk_oe, 1);

        // R4: transmit disabled holds the byte
        rx_en = 1'b1; tx_en = 1'b0;
        clear_mon();
        n0 = rxi_n;
        wr(8'h5A);
        repeat (300) step();
        chk(tog_n == 0, "R4", "no clock while disabled", tog_n, 0);
        chk(tx_empty == 1'b0, "R4", "byte still held", tx_empty, 0);
        tx_en = 1'b1;
        wait_cnt(rxi_n, n0, 2000);
        chk(rx_rdata == 8'h5A, "R4", "enable starts held byte", rx_rdata, 8'h5A);
        rd();

        // R5: receive enabled without a byte starts nothing
        clear_mon();
        n0 = rxi_n;
        repeat (300) step();
        chk(tog_n == 0 && rxi_n == n0, "R5", "idle without tx data", tog_n, 0);

        // directed divisor corners
        int_frame(8'hA5, 1'b0, 1'b1, 2'b00, 8'd0,   1'b0);
        int_frame(8'h3C, 1'b1, 1'b0, 2'b00, 8'd255, 1'b1);
        int_frame(8'h81, 1'b1, 1'b1, 2'b11, 8'd1,   1'b0);

        // constrained random frames
        for (int it = 0; it < 10; it++) begin
            int_frame(8'($urandom), 1'($urandom), 1'($urandom),
                      2'($urandom % 3), 8'($urandom % 4), 1'($urandom));
        end

        // R5: transmit-only frame leaves receive side alone
        keep = rx_rdata;
        rx_en = 1'b0; txirq_sel = 1'b1; presc_sel = 2'b00; baud_div = 8'd2;
        n0 = rxi_n; t0 = txi_n;
        step();
        clear_mon();
        wr(8'hC3);
        wait_cnt(txi_n, t0, 2000);
        chk(ncap == 8, "R5", "tx-only frame ran", ncap, 8);
        chk(rx_rdata == keep && rxi_n == n0, "R5", "rx untouched", rx_rdata, keep);

        // R8: overrun on unread byte
        rx_en = 1'b1; msb_first = 1'b0;
        n0 = rxi_n;
        wr(8'h11);
        wait_cnt(rxi_n, n0, 2000);
        t0 = txi_n; n0 = rxi_n;
        wr(8'h22);
        wait_cnt(txi_n, t0, 2000);
        chk(overrun == 1'b1, "R8", "overrun set", overrun, 1);
        chk(rx_rdata == 8'h11, "R8", "old byte kept", rx_rdata, 8'h11);
        chk(rxi_n == n0, "R8", "no rx_irq for lost frame", rxi_n - n0, 0);
        rd();
        chk(overrun == 1'b1, "R8", "read does not clear overrun", overrun, 1);
        rx_en = 1'b0;
        step(); step();
        chk(overrun == 1'b0, "R8", "rx_en low clears overrun", overrun, 0);

        // R12: continuous receive
        rx_en = 1'b1; cont_rx = 1'b1; txirq_sel = 1'b0;
        n0 = rxi_n;
        wr(8'h96);
        wait_cnt(rxi_n, n0, 2000);
        chk(rx_rdata == 8'h96, "R12", "first frame", rx_rdata, 8'h96);
        n0 = rxi_n; t0 = txi_n;
        rd();
        wait_cnt(rxi_n, n0, 2000);
        chk(rxi_n == n0 + 1, "R12", "read re-arms a frame", rxi_n - n0, 1);
        chk(rx_rdata == 8'h96 && tx_empty == 1'b1, "R12", "resent byte, buffer stays free", rx_rdata, 8'h96);
        chk(txi_n == t0, "R12", "no buffer-moved irq", txi_n - t0, 0);
        clear_mon();
        repeat (500) step();
        chk(tog_n == 0, "R12", "no frame without read", tog_n, 0);
        cont_rx = 1'b0;
        rd();

        // R11 / R9: external clock both polarities
        ext_frame(8'hE1, 8'h4B, 1'b0, 1'b1);
        ext_frame(8'h27, 8'($urandom), 1'b1, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule